// File: doc/BRIEF.md
# Shared-Pool Multi-Queue Cell Buffer

This block stores fixed-size cells arriving on one ingress stream into a single memory of 118 cell slots. That memory is shared by 24 per-port queues. Each queue has its own programmable ceiling of 0 to 6 cells. A ceiling of 0 marks a port as unused. A cell arrives as `CELL_WORDS` consecutive valid words, and the first word is flagged by `in_sop`. The port number sampled on that first word selects the destination queue.

Upstream logic polls the per-port `cell_avail` vector before it starts a cell. A queue's committed fill count changes only after the last word of a cell has been stored. A port that is polled while one of its cells is still in flight therefore still reports room. To cover this race, a started cell is taken with one cell of slack above the ceiling. Free slots sit on a stack of slot indices, and each queue keeps a small ring of the slots it owns.

The consumer selects a queue and reads the head cell word by word. Reading the final word retires the cell and hands its slot back to the free stack in that same cycle. A level output reports an exhausted pool. A sticky flag records any cell refused for lack of a free slot.

Top module: `shared_cell_pool`

## Requirements
- R1: After reset all queues are empty, `pool_full` is 0, `nofree_flag` is 0, and `cell_avail[p]` is 1 exactly for ports whose ceiling is nonzero.
- R2: `cell_avail[p]` is 1 when all three conditions hold: the port's ceiling is nonzero, its committed count is below that ceiling, and the pool has a free slot. The ceiling is `q_limit[3p+2:3p]`, and values above 6 act as 6.
- R3: A queue's committed count, and with it `cell_avail`, changes only in the cycle after the last word of a cell. Words before the last leave it unchanged.
- R4: A first word (`in_valid` and `in_sop` while no cell is in progress) is accepted if three conditions hold: the port's ceiling is nonzero, its committed count is at most the ceiling, and a slot is free. Otherwise the whole cell of `CELL_WORDS` words is discarded.
- R5: Cells sent to a port with ceiling 0, or to a port number of 24 or above, are never stored, and those ports never report room.
- R6: `pool_full` is 1 exactly when no slot is free. Slots held by queued cells and by a cell in progress both count as used.
- R7: A first word refused because no slot is free sets `nofree_flag`. The flag stays set until a one-cycle `nofree_clr` pulse clears it.
- R8: `deq_ok` shows that the queue selected by `deq_port` holds a cell. `deq_data` is word `deq_word` of that queue's oldest cell. Cells leave a queue in arrival order.
- R9: `deq_req` with `deq_ok` and `deq_word` equal to `CELL_WORDS-1` retires the head cell. Its slot becomes free from the next cycle and can be refilled.
- R10: The count of free slots, plus the cells held in all queues, plus the cell in progress, always equals the pool size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| q_limit | input | 72 | Per-port ceiling, 3 bits per port, port p in bits 3p+2:3p |
| cell_avail | output | 24 | Per-port room indication for polling |
| in_valid | input | 1 | Ingress word valid |
| in_sop | input | 1 | Marks the first word of a cell |
| in_port | input | 5 | Destination port, sampled on the first word |
| in_data | input | 16 | Ingress word |
| deq_req | input | 1 | Read request; retires the cell on the last word |
| deq_port | input | 5 | Queue selected for reading |
| deq_word | input | 2 | Word index within the head cell |
| deq_ok | output | 1 | Selected queue holds at least one cell |
| deq_data | output | 16 | Selected word of the head cell |
| pool_full | output | 1 | No free slot in the pool |
| nofree_flag | output | 1 | Sticky: a cell was refused for lack of a slot |
| nofree_clr | input | 1 | Clears `nofree_flag` |

## Verification
One port with a ceiling of 2 receives single cells, a cell stopped before its last word, a third cell inside the slack, and a fourth beyond it. These cases separate commit-at-end timing from commit-at-start timing, and the slack rule from a strict ceiling. Unused ports, out-of-range port numbers and a ceiling of 7 (treated as 6) show that ceiling decoding is separate from pool accounting. A round-robin fill of all 118 slots, then a refused cell, a flag clear, one retire and a refill, exposes faults in the free stack and in the full and sticky logic. Every retired cell is read back word by word, so a slot reused by the wrong queue or in the wrong order shows up as a data mismatch.

// File: rtl/cbuf_pkg.sv
package cbuf_pkg;

  // Effective ceiling: anything above the maximum acts as the maximum.
  function automatic int unsigned eff_limit(input int unsigned raw, input int unsigned max_len);
    return (raw > max_len) ? max_len : raw;
  endfunction

  // Room reported for polling.
  function automatic logic has_room(input int unsigned cnt, input int unsigned lim,
                                    input logic free_nz);
    return (lim != 0) && (cnt < lim) && free_nz;
  endfunction

  // Acceptance of a starting cell: one cell of slack over the ceiling.
  function automatic logic may_accept(input int unsigned cnt, input int unsigned lim,
                                      input logic free_nz);
    return (lim != 0) && (cnt <= lim) && free_nz;
  endfunction

endpackage

// File: rtl/cbuf_free_stack.sv
module cbuf_free_stack #(
  parameter int DEPTH = 118,
  parameter int IW    = 7,
  parameter int FW    = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc,
  input  logic          release_en,
  input  logic [IW-1:0] release_idx,
  output logic [IW-1:0] top_idx,
  output logic [FW-1:0] free_cnt
);
  logic [IW-1:0] stk [DEPTH];
  logic [FW-1:0] sp;

  assign free_cnt = sp;
  assign top_idx  = (sp != '0) ? stk[sp - 1'b1] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) stk[i] <= IW'(i);
      sp <= FW'(DEPTH);
    end else if (alloc && release_en) begin
      stk[sp - 1'b1] <= release_idx;   // freed slot replaces the one taken
    end else if (alloc) begin
      sp <= sp - 1'b1;
    end else if (release_en) begin
      stk[sp] <= release_idx;
      sp      <= sp + 1'b1;
    end
  end
endmodule

// File: rtl/cbuf_queue.sv
module cbuf_queue #(
  parameter int RD = 7,
  parameter int IW = 7,
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [IW-1:0] push_idx,
  input  logic          pop,
  output logic [IW-1:0] head_idx,
  output logic [CW-1:0] count
);
  localparam int PTRW = (RD > 1) ? $clog2(RD) : 1;

  logic [IW-1:0]   ring [RD];
  logic [PTRW-1:0] hd, tl;

  function automatic logic [PTRW-1:0] nxt(input logic [PTRW-1:0] p);
    return (p == PTRW'(RD - 1)) ? '0 : p + 1'b1;
  endfunction

  assign head_idx = ring[hd];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hd    <= '0;
      tl    <= '0;
      count <= '0;
    end else begin
      if (push) begin
        ring[tl] <= push_idx;
        tl       <= nxt(tl);
      end
      if (pop) hd <= nxt(hd);
      if (push && !pop)      count <= count + 1'b1;
      else if (pop && !push) count <= count - 1'b1;
    end
  end
endmodule

// File: rtl/shared_cell_pool.sv
module shared_cell_pool #(
  parameter int NUM_Q      = 24,
  parameter int POOL       = 118,
  parameter int MAX_LEN    = 6,
  parameter int CELL_WORDS = 4,
  parameter int DW         = 16,
  parameter int PW         = $clog2(NUM_Q),
  parameter int LW         = $clog2(MAX_LEN + 1),
  parameter int WW         = $clog2(CELL_WORDS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_Q*LW-1:0] q_limit,
  output logic [NUM_Q-1:0]    cell_avail,
  input  logic                in_valid,
  input  logic                in_sop,
  input  logic [PW-1:0]       in_port,
  input  logic [DW-1:0]       in_data,
  input  logic                deq_req,
  input  logic [PW-1:0]       deq_port,
  input  logic [WW-1:0]       deq_word,
  output logic                deq_ok,
  output logic [DW-1:0]       deq_data,
  output logic                pool_full,
  output logic                nofree_flag,
  input  logic                nofree_clr
);
  import cbuf_pkg::*;

  localparam int SW = $clog2(POOL);
  localparam int FW = $clog2(POOL + 1);
  localparam int RD = MAX_LEN + 1;
  localparam int CW = $clog2(RD + 1);
  localparam int TW = $clog2(NUM_Q * RD + 1);

  // Per-port ceilings and queue state
  logic [LW-1:0] lim     [NUM_Q];
  logic [CW-1:0] q_cnt   [NUM_Q];
  logic [SW-1:0] q_head  [NUM_Q];

  // Pool state
  logic [SW-1:0] top_idx;
  logic [FW-1:0] free_cnt;
  logic          free_nz;
  logic [DW-1:0] mem [POOL][CELL_WORDS];

  // Ingress state
  logic          busy, keep;
  logic [SW-1:0] cur_slot;
  logic [PW-1:0] cur_port;
  logic [WW-1:0] wcnt;

  // Named events
  logic          start_ev, accept_ev, nofree_ev, last_word, commit_ev, release_ev;
  logic          in_flight;
  logic [LW-1:0] in_lim;
  logic [CW-1:0] in_cnt, deq_cnt;
  logic [SW-1:0] deq_head;
  logic [TW-1:0] queued_total;

  assign free_nz   = (free_cnt != '0);
  assign pool_full = !free_nz;

  always_comb begin
    for (int p = 0; p < NUM_Q; p++) begin
      lim[p]        = LW'(eff_limit(int'(q_limit[p*LW +: LW]), MAX_LEN));
      cell_avail[p] = has_room(int'(q_cnt[p]), int'(lim[p]), free_nz);
    end
  end

  // Port selection (numbers at or above NUM_Q match nothing)
  always_comb begin
    in_lim   = '0;
    in_cnt   = '0;
    deq_cnt  = '0;
    deq_head = '0;
    queued_total = '0;
    for (int p = 0; p < NUM_Q; p++) begin
      if (in_port == PW'(p)) begin
        in_lim = lim[p];
        in_cnt = q_cnt[p];
      end
      if (deq_port == PW'(p)) begin
        deq_cnt  = q_cnt[p];
        deq_head = q_head[p];
      end
      queued_total = queued_total + TW'(q_cnt[p]);
    end
  end

  assign start_ev   = in_valid && in_sop && !busy;
  assign accept_ev  = start_ev && may_accept(int'(in_cnt), int'(in_lim), free_nz);
  assign nofree_ev  = start_ev && !free_nz;
  assign last_word  = busy && in_valid && (wcnt == WW'(CELL_WORDS - 1));
  assign commit_ev  = last_word && keep;
  assign in_flight  = busy && keep;
  assign deq_ok     = (deq_cnt != '0);
  assign release_ev = deq_req && deq_ok && (deq_word == WW'(CELL_WORDS - 1));
  assign deq_data   = mem[deq_head][deq_word];

  cbuf_free_stack #(.DEPTH(POOL), .IW(SW), .FW(FW)) u_free (
    .clk        (clk),
    .rst_n      (rst_n),
    .alloc      (accept_ev),
    .release_en (release_ev),
    .release_idx(deq_head),
    .top_idx    (top_idx),
    .free_cnt   (free_cnt)
  );

  for (genvar q = 0; q < NUM_Q; q++) begin : g_q
    cbuf_queue #(.RD(RD), .IW(SW), .CW(CW)) u_queue (
      .clk     (clk),
      .rst_n   (rst_n),
      .push    (commit_ev && (cur_port == PW'(q))),
      .push_idx(cur_slot),
      .pop     (release_ev && (deq_port == PW'(q))),
      .head_idx(q_head[q]),
      .count   (q_cnt[q])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      keep     <= 1'b0;
      cur_slot <= '0;
      cur_port <= '0;
      wcnt     <= '0;
    end else if (start_ev) begin
      busy     <= 1'b1;
      keep     <= accept_ev;
      cur_slot <= top_idx;
      cur_port <= in_port;
      wcnt     <= WW'(1);
    end else if (busy && in_valid) begin
      if (last_word) busy <= 1'b0;
      wcnt <= wcnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (accept_ev)                  mem[top_idx][0]     <= in_data;
    else if (busy && keep && in_valid) mem[cur_slot][wcnt] <= in_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         nofree_flag <= 1'b0;
    else if (nofree_ev) nofree_flag <= 1'b1;
    else if (nofree_clr) nofree_flag <= 1'b0;
  end
endmodule

// File: rtl/cbuf_checker.sv
module cbuf_checker #(
  parameter int NUM_Q = 24,
  parameter int POOL  = 118,
  parameter int FW    = 7,
  parameter int TW    = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [FW-1:0]    free_cnt,
  input logic [TW-1:0]    queued_total,
  input logic             in_flight,
  input logic             accept_ev,
  input logic             commit_ev,
  input logic             release_ev,
  input logic             nofree_ev,
  input logic             nofree_flag,
  input logic             nofree_clr,
  input logic             pool_full,
  input logic [NUM_Q-1:0] cell_avail
);
  // R10
  slot_conservation_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(free_cnt) + int'(queued_total) + (in_flight ? 1 : 0)) == POOL);

  // R7
  nofree_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nofree_ev |=> nofree_flag);

  // R7
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nofree_flag && !nofree_clr) |=> nofree_flag);

  // R2
  full_no_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pool_full |-> (cell_avail == '0));

  // R4
  accept_needs_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_ev |-> !pool_full);

  // R3
  commit_grows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_ev && !release_ev) |=> (queued_total == $past(queued_total) + 1'b1));

  // R3
  no_commit_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!commit_ev && !release_ev) |=> $stable(queued_total));
endmodule

bind shared_cell_pool cbuf_checker #(.NUM_Q(NUM_Q), .POOL(POOL), .FW(FW), .TW(TW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .free_cnt    (free_cnt),
  .queued_total(queued_total),
  .in_flight   (in_flight),
  .accept_ev   (accept_ev),
  .commit_ev   (commit_ev),
  .release_ev  (release_ev),
  .nofree_ev   (nofree_ev),
  .nofree_flag (nofree_flag),
  .nofree_clr  (nofree_clr),
  .pool_full   (pool_full),
  .cell_avail  (cell_avail)
);

// File: tb/shared_cell_pool_test.sv
module shared_cell_pool_test;
  localparam int NQ = 24;
  localparam int CWORDS = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NQ*3-1:0] q_limit = '0;
  logic [NQ-1:0] cell_avail;
  logic          in_valid = 1'b0, in_sop = 1'b0;
  logic [4:0]    in_port = '0;
  logic [15:0]   in_data = '0;
  logic          deq_req = 1'b0;
  logic [4:0]    deq_port = '0;
  logic [1:0]    deq_word = '0;
  logic          deq_ok;
  logic [15:0]   deq_data;
  logic          pool_full, nofree_flag;
  logic          nofree_clr = 1'b0;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  shared_cell_pool uut (
    .clk(clk), .rst_n(rst_n), .q_limit(q_limit), .cell_avail(cell_avail),
    .in_valid(in_valid), .in_sop(in_sop), .in_port(in_port), .in_data(in_data),
    .deq_req(deq_req), .deq_port(deq_port), .deq_word(deq_word),
    .deq_ok(deq_ok), .deq_data(deq_data), .pool_full(pool_full),
    .nofree_flag(nofree_flag), .nofree_clr(nofree_clr)
  );

  always #5 clk = ~clk;

  task automatic check(input bit cond, input string req, input longint act, input longint exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] base_of(input int port, input int k);
    return 16'(port * 256 + k * 8);
  endfunction

  task automatic set_lim(input int p, input int v);
    q_limit[p*3 +: 3] = 3'(v);
  endtask

  task automatic send_words(input int port, input logic [15:0] base, input int from, input int upto);
    for (int w = from; w < upto; w++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_sop   = (w == 0);
      in_port  = 5'(port);
      in_data  = base + 16'(w);
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_sop   = 1'b0;
  endtask

  task automatic send_cell(input int port, input logic [15:0] base);
    send_words(port, base, 0, CWORDS);
  endtask

  // Reads and retires the head cell, checking every word (R8, R9)
  task automatic deq_cell(input int port, input logic [15:0] base, input string req);
    @(negedge clk);
    deq_port = 5'(port);
    #1;
    check(deq_ok == 1'b1, req, deq_ok, 1);
    for (int w = 0; w < CWORDS; w++) begin
      deq_word = 2'(w);
      deq_req  = (w == CWORDS - 1);
      #1;
      check(deq_data == base + 16'(w), req, deq_data, base + 16'(w));
      if (w < CWORDS - 1) @(negedge clk);
    end
    @(negedge clk);
    deq_req = 1'b0;
  endtask

  task automatic expect_empty(input int port, input string req);
    @(negedge clk);
    deq_port = 5'(port);
    #1;
    check(deq_ok == 1'b0, req, deq_ok, 0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(cell_avail == 24'h00000D, "R1 avail", cell_avail, 24'h00000D);
    check(pool_full == 1'b0, "R1 full", pool_full, 0);
    check(nofree_flag == 1'b0, "R1 flag", nofree_flag, 0);
    expect_empty(0, "R1 empty");
  endtask

  task automatic t_commit_timing;
    // R3: three words in, count not yet committed
    send_words(0, base_of(0, 0), 0, CWORDS - 1);
    @(negedge clk);
    in_valid = 1'b1; in_port = 5'd0; in_data = base_of(0, 0) + 16'(CWORDS - 1);
    // before the final edge, still nothing queued
    check(cell_avail[0] == 1'b1, "R3 midcell", cell_avail[0], 1);
    @(negedge clk);
    in_valid = 1'b0;
    check(cell_avail[0] == 1'b1, "R2 one of two", cell_avail[0], 1);
    send_cell(0, base_of(0, 1));
    check(cell_avail[0] == 1'b0, "R2 at limit", cell_avail[0], 0);
    send_cell(0, base_of(0, 2));   // R4: inside slack, taken
    send_cell(0, base_of(0, 3));   // R4: beyond slack, dropped
    deq_cell(0, base_of(0, 0), "R8 order0");
    deq_cell(0, base_of(0, 1), "R8 order1");
    deq_cell(0, base_of(0, 2), "R4 slack cell");
    expect_empty(0, "R4 dropped beyond slack");
    check(cell_avail[0] == 1'b1, "R2 room again", cell_avail[0], 1);
  endtask

  task automatic t_unused;
    send_cell(1, base_of(1, 0));
    expect_empty(1, "R5 limit zero");
    send_cell(30, base_of(30, 0));
    expect_empty(30, "R5 port out of range");
    check(cell_avail[1] == 1'b0, "R5 no room", cell_avail[1], 0);
  endtask

  task automatic t_clamp;
    for (int k = 0; k < 5; k++) send_cell(3, base_of(3, k));
    check(cell_avail[3] == 1'b1, "R2 clamp below", cell_avail[3], 1);
    send_cell(3, base_of(3, 5));
    check(cell_avail[3] == 1'b0, "R2 clamp to six", cell_avail[3], 0);
    for (int k = 0; k < 6; k++) deq_cell(3, base_of(3, k), "R8 clamp drain");
  endtask

  task automatic t_fill;
    for (int p = 4; p < NQ; p++) set_lim(p, 6);
    for (int i = 0; i < 118; i++) send_cell(4 + i % 20, base_of(4 + i % 20, i / 20));
    check(pool_full == 1'b1, "R6 full", pool_full, 1);
    check(cell_avail == '0, "R2 full no room", cell_avail, 0);
    check(nofree_flag == 1'b0, "R7 not yet", nofree_flag, 0);
    send_cell(0, base_of(0, 7));
    check(nofree_flag == 1'b1, "R7 set", nofree_flag, 1);
    expect_empty(0, "R7 refused cell");
    @(negedge clk);
    check(nofree_flag == 1'b1, "R7 sticky", nofree_flag, 1);
    nofree_clr = 1'b1;
    @(negedge clk);
    nofree_clr = 1'b0;
    check(nofree_flag == 1'b0, "R7 cleared", nofree_flag, 0);
    deq_cell(4, base_of(4, 0), "R9 retire");
    check(pool_full == 1'b0, "R9 slot freed", pool_full, 0);
    check(cell_avail[0] == 1'b1, "R9 room back", cell_avail[0], 1);
    send_cell(0, base_of(0, 9));
    check(pool_full == 1'b1, "R6 full again", pool_full, 1);
    deq_cell(0, base_of(0, 9), "R9 reused slot");
    deq_cell(5, base_of(5, 0), "R8 other queue");
  endtask

  initial begin
    set_lim(0, 2);
    set_lim(2, 1);
    set_lim(3, 7);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_commit_timing();
    t_unused();
    t_clamp();
    t_fill();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule